// File: doc/BRIEF.md
# Circular Receive Message Buffer Manager

This block stores received messages for one receive subaddress of a serial command/response bus terminal into a ring-shaped region of RAM. A small descriptor holds four registers: control, start, current and end. Each accepted message goes into RAM as a run of consecutive words, beginning at the current address. The first word is a message-info word, the second is a time-tag word, and the data words follow.

Once the final word is stored, the block decides where the next message will begin. It takes the next free address and compares it against the end address. If the next free address is still below the end address, the current address moves to it. Otherwise the current address reloads from the start address, a wrap interrupt may fire, and a sticky wrap flag is set. The wrap decision is made only after the whole message is stored. A message that begins below the end address is therefore never split across the wrap; it runs on into a pad area of up to 33 words past the end address.

The host loads the descriptor through a simple register write port. The message source gives a start strobe, the data word count (0 to 32), the info word and the time-tag word. Data words arrive on `data_i` as the RAM accepts them.

Top module: `rx_ring_buf`

## Requirements
- R1: After reset the current address is 0, `irq_o`, `wrap_flag_o` and `busy_o` are low, and `ram_we_o` is low.
- R2: A message with N data words is written as exactly N+2 consecutive RAM words starting at the current address. The order is: info word, then time-tag word, then data words in arrival order.
- R3: Exactly one word is written per cycle in which `ram_we_o` and `ram_rdy_i` are both high. While `ram_rdy_i` is low, the address and data are held.
- R4: If the last written address + 1 is below the end address, the current address becomes last written address + 1, one cycle after the update cycle that follows the final write.
- R5: If the last written address + 1 is greater than or equal to the end address, the current address is reloaded with the start address. Equality counts as a wrap.
- R6: On a wrap, `irq_o` pulses high for exactly one cycle, but only when control bit 0 is set. With bit 0 clear, the current address still wraps and no pulse appears.
- R7: `wrap_flag_o` is set on every wrap and stays set until a `wrap_clr_i` pulse clears it.
- R8: A message that starts below the end address is written in full, even at addresses past the end address.
- R9: A message with zero data words writes only the info and time-tag words, and the wrap rule uses the time-tag address + 1.
- R10: Descriptor writes (`desc_sel_i`: 0 control, 1 start, 2 current, 3 end) are ignored while `busy_o` is high.
- R11: `msg_start_i` is ignored while `busy_o` is high, and also when control bit 15 (circular mode enable) is clear.
- R12: After a wrap, the next message overwrites RAM starting at the start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| desc_we_i | input | 1 | Descriptor write strobe |
| desc_sel_i | input | 2 | Descriptor register select |
| desc_wdata_i | input | 16 | Descriptor write data |
| wrap_clr_i | input | 1 | Clears the sticky wrap flag |
| msg_start_i | input | 1 | Start-of-message strobe |
| msg_cnt_i | input | 6 | Data word count, 0 to 32 |
| msg_info_i | input | 16 | Message-info word |
| msg_ttag_i | input | 16 | Time-tag word |
| data_i | input | 16 | Current data word, consumed on each accepted data write |
| ram_rdy_i | input | 1 | RAM accepts a write this cycle |
| ram_we_o | output | 1 | RAM write request |
| ram_addr_o | output | 16 | RAM write address |
| ram_wdata_o | output | 16 | RAM write data |
| busy_o | output | 1 | Message in progress |
| curr_addr_o | output | 16 | Current address register |
| irq_o | output | 1 | Wrap interrupt pulse |
| wrap_flag_o | output | 1 | Sticky wrap flag |

## Verification
The bench sweeps every data count from 0 to 32 through a 128-word ring, first with the interrupt enabled and then with it disabled. RAM acceptance is throttled throughout, so wraps land at many offsets. A design that splits messages at the end address, or decides the wrap word by word, would write to the wrong addresses or move the current address at the wrong moment. Exact-equality wraps and zero-count wraps are aimed at off-by-one comparisons, which would leave the current address sitting on the end address. The bench also pokes the descriptor and the start strobe during a message; a design that honours those writes would corrupt the final current address or the word count.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_INFO, ST_TTAG, ST_DATA, ST_UPD
  } ring_state_e;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_START = 2'd1;
  localparam logic [1:0] SEL_CURR  = 2'd2;
  localparam logic [1:0] SEL_END   = 2'd3;

  localparam int CTRL_IRQ_BIT  = 0;
  localparam int CTRL_MODE_BIT = 15;
endpackage

// File: rtl/rx_ring_seq.sv
module rx_ring_seq
  import rx_ring_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [DW-1:0]    info_i,
  input  logic [DW-1:0]    ttag_i,
  input  logic [DW-1:0]    data_i,
  input  logic [AW-1:0]    cur_i,
  input  logic             ram_rdy_i,
  output logic             ram_we_o,
  output logic [AW-1:0]    ram_addr_o,
  output logic [DW-1:0]    ram_wdata_o,
  output logic             busy_o,
  output logic             upd_o,
  output logic [AW-1:0]    next_o
);
  ring_state_e      state_q;
  logic [AW-1:0]    ptr_q;
  logic [CNT_W-1:0] rem_q;
  logic [DW-1:0]    info_q, ttag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      rem_q   <= '0;
      info_q  <= '0;
      ttag_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i && mode_en_i) begin
          info_q  <= info_i;
          ttag_q  <= ttag_i;
          rem_q   <= cnt_i;
          ptr_q   <= cur_i;
          state_q <= ST_INFO;
        end
        ST_INFO: if (ram_rdy_i) begin
          ptr_q   <= ptr_q + 1'b1;
          state_q <= ST_TTAG;
        end
        ST_TTAG: if (ram_rdy_i) begin
          ptr_q   <= ptr_q + 1'b1;
          state_q <= (rem_q == '0) ? ST_UPD : ST_DATA;
        end
        ST_DATA: if (ram_rdy_i) begin
          ptr_q <= ptr_q + 1'b1;
          rem_q <= rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) state_q <= ST_UPD;
        end
        ST_UPD:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ram_we_o    = (state_q == ST_INFO) || (state_q == ST_TTAG) || (state_q == ST_DATA);
    ram_addr_o  = ptr_q;
    unique case (state_q)
      ST_INFO: ram_wdata_o = info_q;
      ST_TTAG: ram_wdata_o = ttag_q;
      ST_DATA: ram_wdata_o = data_i;
      default: ram_wdata_o = '0;
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);
  assign upd_o  = (state_q == ST_UPD);
  assign next_o = ptr_q;  // last written address + 1 during ST_UPD

  p_addr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && ram_rdy_i) |=> (!ram_we_o || ram_addr_o == $past(ram_addr_o) + 1'b1));

  p_stall_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && !ram_rdy_i) |=> (ram_we_o && $stable(ram_addr_o)));

  p_upd_after_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !busy_o);
endmodule

// File: rtl/rx_ring_desc.sv
module rx_ring_desc
  import rx_ring_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wrap_clr_i,
  input  logic          busy_i,
  input  logic          upd_i,
  input  logic [AW-1:0] next_i,
  output logic [AW-1:0] cur_o,
  output logic          mode_en_o,
  output logic          irq_o,
  output logic          wrap_flag_o
);
  logic [DW-1:0] ctrl_q;
  logic [AW-1:0] start_q, curr_q, end_q;
  logic          irq_q, flag_q;
  logic          wrap;

  // Wrap is judged once per message, on the next free address
  assign wrap = upd_i && (next_i >= end_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      start_q <= '0;
      curr_q  <= '0;
      end_q   <= '0;
      irq_q   <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      irq_q <= wrap && ctrl_q[CTRL_IRQ_BIT];
      if (wrap)            flag_q <= 1'b1;
      else if (wrap_clr_i) flag_q <= 1'b0;
      if (upd_i) begin
        curr_q <= wrap ? start_q : next_i;
      end else if (we_i && !busy_i) begin
        unique case (sel_i)
          SEL_CTRL:  ctrl_q  <= wdata_i;
          SEL_START: start_q <= AW'(wdata_i);
          SEL_CURR:  curr_q  <= AW'(wdata_i);
          SEL_END:   end_q   <= AW'(wdata_i);
          default: ;
        endcase
      end
    end
  end

  assign cur_o       = curr_q;
  assign mode_en_o   = ctrl_q[CTRL_MODE_BIT];
  assign irq_o       = irq_q;
  assign wrap_flag_o = flag_q;

  p_irq_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);

  p_wrap_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> (curr_q == $past(start_q)));

  p_hold_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !upd_i) |=> $stable(curr_q));

  p_flag_on_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> flag_q);
endmodule

// File: rtl/rx_ring_buf.sv
module rx_ring_buf
  import rx_ring_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int MAX_WORDS = 32,
  localparam int CNT_W    = $clog2(MAX_WORDS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             desc_we_i,
  input  logic [1:0]       desc_sel_i,
  input  logic [DW-1:0]    desc_wdata_i,
  input  logic             wrap_clr_i,
  input  logic             msg_start_i,
  input  logic [CNT_W-1:0] msg_cnt_i,
  input  logic [DW-1:0]    msg_info_i,
  input  logic [DW-1:0]    msg_ttag_i,
  input  logic [DW-1:0]    data_i,
  input  logic             ram_rdy_i,
  output logic             ram_we_o,
  output logic [AW-1:0]    ram_addr_o,
  output logic [DW-1:0]    ram_wdata_o,
  output logic             busy_o,
  output logic [AW-1:0]    curr_addr_o,
  output logic             irq_o,
  output logic             wrap_flag_o
);
  logic          mode_en, upd;
  logic [AW-1:0] cur, next_free;

  rx_ring_desc #(.AW(AW), .DW(DW)) u_desc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (desc_we_i),
    .sel_i       (desc_sel_i),
    .wdata_i     (desc_wdata_i),
    .wrap_clr_i  (wrap_clr_i),
    .busy_i      (busy_o),
    .upd_i       (upd),
    .next_i      (next_free),
    .cur_o       (cur),
    .mode_en_o   (mode_en),
    .irq_o       (irq_o),
    .wrap_flag_o (wrap_flag_o)
  );

  rx_ring_seq #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (msg_start_i),
    .mode_en_i   (mode_en),
    .cnt_i       (msg_cnt_i),
    .info_i      (msg_info_i),
    .ttag_i      (msg_ttag_i),
    .data_i      (data_i),
    .cur_i       (cur),
    .ram_rdy_i   (ram_rdy_i),
    .ram_we_o    (ram_we_o),
    .ram_addr_o  (ram_addr_o),
    .ram_wdata_o (ram_wdata_o),
    .busy_o      (busy_o),
    .upd_o       (upd),
    .next_o      (next_free)
  );

  assign curr_addr_o = cur;

  p_start_at_curr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && msg_start_i && mode_en) |=> (ram_we_o && ram_addr_o == $past(curr_addr_o)));

  p_idle_no_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !mode_en) |=> !ram_we_o);
endmodule

// File: tb/rx_ring_buf_tb.sv
module rx_ring_buf_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        desc_we = 1'b0;
  logic [1:0]  desc_sel = '0;
  logic [15:0] desc_wdata = '0;
  logic        wrap_clr = 1'b0;
  logic        msg_start = 1'b0;
  logic [5:0]  msg_cnt = '0;
  logic [15:0] msg_info = '0, msg_ttag = '0, data = '0;
  logic        ram_rdy = 1'b1;
  logic        ram_we, busy, irq, wrap_flag;
  logic [15:0] ram_addr, ram_wdata, curr_addr;

  int checks = 0, failures = 0;
  logic [15:0] m_ctrl, m_start, m_end, m_curr, last_addr;

  always #2 clk = ~clk;

  rx_ring_buf u_dut (
    .clk_i(clk), .rst_ni(rst_n), .desc_we_i(desc_we), .desc_sel_i(desc_sel),
    .desc_wdata_i(desc_wdata), .wrap_clr_i(wrap_clr), .msg_start_i(msg_start),
    .msg_cnt_i(msg_cnt), .msg_info_i(msg_info), .msg_ttag_i(msg_ttag), .data_i(data),
    .ram_rdy_i(ram_rdy), .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata),
    .busy_o(busy), .curr_addr_o(curr_addr), .irq_o(irq), .wrap_flag_o(wrap_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wdesc(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    desc_we = 1'b1; desc_sel = sel; desc_wdata = val;
    @(negedge clk);
    desc_we = 1'b0;
    #1;
  endtask

  task automatic setup(input logic [15:0] c, input logic [15:0] s, input logic [15:0] e, input logic [15:0] cur);
    wdesc(2'd0, c); wdesc(2'd1, s); wdesc(2'd3, e); wdesc(2'd2, cur);
    m_ctrl = c; m_start = s; m_end = e; m_curr = cur;
  endtask

  // Sends one message; stall>0 throttles ram_rdy; poke disturbs descriptor/start mid-message
  task automatic run_msg(input int cnt, input int stall, input bit poke);
    int idx = 0, cyc = 0, errs = 0;
    logic [15:0] nxt, exp_cur, expd;
    bit wrapped, exp_irq;
    nxt = m_curr + 16'(2 + cnt);
    wrapped = (nxt >= m_end);
    exp_cur = wrapped ? m_start : nxt;
    exp_irq = wrapped && m_ctrl[0];
    @(negedge clk);
    msg_start = 1'b1; msg_cnt = 6'(cnt);
    msg_info = 16'hA000 + 16'(cnt); msg_ttag = 16'hB000 + 16'(cnt);
    @(negedge clk);
    msg_start = 1'b0; msg_info = '0; msg_ttag = '0;
    forever begin
      ram_rdy = (stall == 0) ? 1'b1 : ((cyc + stall) % 3 != 0);
      data = (idx >= 2) ? 16'hD000 + 16'(idx - 2) : 16'h0;
      if (poke && idx == 3) begin
        desc_we = 1'b1; desc_sel = 2'd2; desc_wdata = 16'h0777;
        msg_start = 1'b1;
      end
      #1;
      if (!ram_we) break;
      expd = (idx == 0) ? 16'hA000 + 16'(cnt) : (idx == 1) ? 16'hB000 + 16'(cnt) : 16'hD000 + 16'(idx - 2);
      if (ram_addr != m_curr + 16'(idx) || ram_wdata != expd) begin
        errs++;
        if (errs == 1) $display("FAIL R2/R3 word %0d addr=%0h data=%0h exp_addr=%0h exp_data=%0h",
                                idx, ram_addr, ram_wdata, m_curr + 16'(idx), expd);
      end
      if (ram_rdy) begin last_addr = ram_addr; idx++; end
      cyc++;
      @(negedge clk);
      desc_we = 1'b0; msg_start = 1'b0;
    end
    ram_rdy = 1'b1;
    chk(errs == 0, "R2 R3 word order/address", 32'(errs), 0);
    chk(idx == cnt + 2, "R2 R9 word count", 32'(idx), 32'(cnt + 2));
    @(negedge clk); #1;
    chk(curr_addr == exp_cur, wrapped ? "R5 wrap to start" : "R4 advance", 32'(curr_addr), 32'(exp_cur));
    chk(irq == exp_irq, "R6 irq on wrap", 32'(irq), 32'(exp_irq));
    chk(!busy, "R4 idle after update", 32'(busy), 0);
    @(negedge clk); #1;
    chk(!irq, "R6 irq single cycle", 32'(irq), 0);
    if (wrapped) chk(wrap_flag, "R7 flag set", 32'(wrap_flag), 1);
    m_curr = exp_cur;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #9; rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(curr_addr == 0 && !irq && !wrap_flag && !busy && !ram_we, "R1 reset", 
        {curr_addr, 12'h0, irq, wrap_flag, busy, ram_we}, 0);

    // Worked example: 3 full messages, third spills past end and wraps (R8, R5)
    setup(16'h8001, 16'h0500, 16'h0545, 16'h0500);
    run_msg(32, 0, 0);
    chk(m_curr == 16'h0522, "R4 example msg1", 32'(m_curr), 32'h0522);
    run_msg(32, 0, 0);
    chk(m_curr == 16'h0544, "R4 example msg2", 32'(m_curr), 32'h0544);
    run_msg(32, 0, 0);
    chk(last_addr == 16'h0565, "R8 spill past end", 32'(last_addr), 32'h0565);
    // R12 next message overwrites from start
    run_msg(5, 1, 0);
    chk(last_addr == 16'h0506, "R12 overwrite from start", 32'(last_addr), 32'h0506);

    // R7 clear sticky flag
    @(negedge clk); wrap_clr = 1'b1; @(negedge clk); wrap_clr = 1'b0; #1;
    chk(!wrap_flag, "R7 flag cleared", 32'(wrap_flag), 0);

    // R5 exact equality wraps
    setup(16'h8001, 16'h0500, 16'h0522, 16'h0500);
    run_msg(32, 2, 0);
    chk(m_curr == 16'h0500, "R5 equality wrap", 32'(m_curr), 32'h0500);
    // R9 zero-count at end-2 wraps; at end-3 does not
    setup(16'h8001, 16'h0200, 16'h0210, 16'h020D);
    run_msg(0, 0, 0);
    chk(m_curr == 16'h020F, "R9 zero count advance", 32'(m_curr), 32'h020F);
    setup(16'h8001, 16'h0200, 16'h0210, 16'h020E);
    run_msg(0, 1, 0);
    chk(m_curr == 16'h0200, "R9 zero count wrap", 32'(m_curr), 32'h0200);

    // Sweep all counts, irq enabled then disabled, with throttling
    setup(16'h8001, 16'h0100, 16'h0180, 16'h0100);
    for (int c = 0; c <= 32; c++) run_msg(c, c % 4, 0);
    m_ctrl = 16'h8000; wdesc(2'd0, 16'h8000);
    for (int c = 32; c >= 0; c--) run_msg(c, (c + 1) % 4, 0);

    // R10 R11 descriptor write and start strobe ignored mid-message
    setup(16'h8001, 16'h0300, 16'h0340, 16'h0310);
    run_msg(8, 2, 1);
    chk(m_curr == 16'h031A, "R10 busy desc write ignored", 32'(curr_addr), 32'h031A);
    repeat (3) begin
      @(negedge clk); #1;
      chk(!ram_we && !busy, "R11 busy start ignored", 32'(ram_we), 0);
    end

    // R11 mode disabled: start ignored
    wdesc(2'd0, 16'h0001);
    @(negedge clk); msg_start = 1'b1; msg_cnt = 6'd4;
    @(negedge clk); msg_start = 1'b0;
    repeat (3) begin
      #1;
      chk(!ram_we && !busy, "R11 mode off ignored", 32'(ram_we), 0);
      @(negedge clk);
    end
    #1;
    chk(curr_addr == 16'h031A, "R11 curr unchanged", 32'(curr_addr), 32'h031A);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule